// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

This block is a 16-bit up-counter whose count rate is set by a 3-bit source-select field. Seven codes pick the bus clock divided by a power of two, from 1 to 64. The eighth code picks an external clock pin. That pin is brought into the bus clock domain by a synchronizer, and the counter steps once for each rising edge of the pin. When the count rolls over, a sticky overflow flag is raised, and software clears it by writing a one to it.

Software controls the block through a small register bus. It can halt counting with a stop bit, and it can restart the count and the divider from zero with a self-clearing clear bit. After reset the block is stopped. A capture-enable output is low while the counter is halted, so that neighbouring capture logic can be qualified by it.

Register map. Address 0 is the control/status word:
- bit 7: overflow flag, write 1 to clear
- bit 5: stop
- bit 4: counter clear, reads 0
- bits 2:0: source select

Address 1 returns the count, zero-extended. Any other address reads 0. Read data is registered: a read returns the state as it was at the clock edge that loads `bus_rdata`.

Top module: `tmr_prescaled_counter`

## Requirements
- R1: After reset, the control word reads 0x0020: stop=1, select=000, flag=0. The count reads 0 and stays 0. `capture_en` and `ovf_flag` are 0.
- R2: While the stop bit (bit 5) is 1, the count holds its value. After a write with bit 5 = 0, counting resumes.
- R3: One cycle after a control write, `capture_en` equals the inverse of the written stop bit (bit 5).
- R4: A control write with bit 4 = 1 clears the count and the divider in that cycle. With select code k (0 to 6) and stop=0, the count reads (m >> k) m cycles after that write.
- R5: Bit 4 always reads 0. A clear write with bit 7 = 0 leaves the overflow flag unchanged.
- R6: A single write with both bit 5 and bit 4 set leaves the count at 0, and the count stays there.
- R7: Select codes 000 to 110 divide the bus clock by 1, 2, 4, 8, 16, 32 and 64 respectively.
- R8: Select code 111 counts rising edges of `ext_clk_in` through a two-flop synchronizer: exactly one count per rising edge, and none while the pin stays high.
- R9: The count wraps from 0xFFFF to 0x0000 and sets `ovf_flag` (bit 7). The flag stays set until a control write with bit 7 = 1 clears it.
- R10: `bus_rdata` is loaded on each clock edge from the address presented before that edge: 0 selects the control word, 1 selects the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| ovf_flag | output | 1 | Sticky overflow flag |
| capture_en | output | 1 | High while the counter runs |

## Verification
The divider is tested at every ratio. For each ratio, the count is read one cycle before and exactly at the fifth divided tick after a clear. This shows both that the ratio is right and that the clear also resets the divider phase. Pulses on the external pin, and a pin held high for a long time, show the difference between edge counting and level counting. A full 65536-step run at ratio 1 checks the flag just before and just after the wrap. Combined stop and clear writes, and stop-only writes, check that the count holds and that no flag bit is disturbed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned CNT_ADDR  = 1;
  localparam int unsigned BIT_FLAG  = 7;
  localparam int unsigned BIT_STOP  = 5;
  localparam int unsigned BIT_CLR   = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned NCODES = 1 << SEL_W;
  localparam int unsigned NRATIO = NCODES - 1;
  localparam int unsigned DIV_W  = NRATIO - 1;

  logic [DIV_W-1:0]  div_q;
  logic [NCODES-1:0] tick_vec;

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  // one pulse each time the low k bits of the divider wrap
  for (genvar k = 0; k < NCODES; k++) begin : g_tap
    if (k == 0) begin : g_div1
      assign tick_vec[k] = 1'b1;
    end else if (k < NRATIO) begin : g_divk
      assign tick_vec[k] = &div_q[k-1:0];
    end else begin : g_none
      assign tick_vec[k] = 1'b0;
    end
  end

  assign tick = tick_vec[sel];
endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             halt,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic step;
  assign step = inc & ~halt & ~clr;
  assign wrap = step & (&cnt);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output logic              stop_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              flag_q,
  output logic              cap_q,
  output logic              clr_req
);
  logic              wr_ctrl;
  logic [DATA_W-1:0] rd_word;
  logic              wdata_unused;

  assign wr_ctrl      = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign clr_req      = wr_ctrl && bus_wdata[BIT_CLR];
  assign wdata_unused = ^{bus_wdata[DATA_W-1:BIT_FLAG+1], bus_wdata[BIT_STOP+1],
                          bus_wdata[BIT_CLR-1:SEL_W]};

  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_word[BIT_FLAG]  = flag_q;
      rd_word[BIT_STOP]  = stop_q;
      rd_word[SEL_W-1:0] = sel_q;
    end else if (bus_addr == ADDR_W'(CNT_ADDR)) begin
      rd_word[CNT_W-1:0] = cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q    <= 1'b1;
      sel_q     <= '0;
      cap_q     <= 1'b0;
      flag_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        stop_q <= bus_wdata[BIT_STOP];
        sel_q  <= bus_wdata[SEL_W-1:0];
        cap_q  <= ~bus_wdata[BIT_STOP];
      end
      if (wrap)                              flag_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[BIT_FLAG]) flag_q <= 1'b0;
      bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/tmr_prescaled_counter.sv
module tmr_prescaled_counter #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk_in,
  output logic              ovf_flag,
  output logic              capture_en
);
  localparam logic [SEL_W-1:0] EXT_CODE = {SEL_W{1'b1}};

  logic             stop_q, clr_req, pre_tick, ext_rise, inc, wrap;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;

  tmr_ctrl_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt(cnt_q), .wrap(wrap), .stop_q(stop_q), .sel_q(sel_q),
    .flag_q(ovf_flag), .cap_q(capture_en), .clr_req(clr_req)
  );

  tmr_prescaler #(.SEL_W(SEL_W)) pre_i (
    .clk(clk), .rst(rst), .clr(clr_req), .sel(sel_q), .tick(pre_tick)
  );

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .pin(ext_clk_in), .rise(ext_rise)
  );

  assign inc = (sel_q == EXT_CODE) ? ext_rise : pre_tick;

  tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .clr(clr_req), .inc(inc), .halt(stop_q),
    .cnt(cnt_q), .wrap(wrap)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic             wd_stop,
  input logic             wd_clr,
  input logic             wd_flag,
  input logic             addr_ctrl,
  input logic             rd_clr_bit,
  input logic             capture_en,
  input logic             ovf_flag,
  input logic [CNT_W-1:0] cnt
);
  // R3
  p_cap_on_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !wd_stop) |=> capture_en);
  p_cap_off_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wd_stop) |=> !capture_en);
  // R2
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!capture_en && !(ctl_wr && wd_clr)) |=> $stable(cnt));
  // R4
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wd_clr) |=> (cnt == '0));
  // R7
  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));
  // R9
  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == {CNT_W{1'b1}} && cnt == '0 && !$past(ctl_wr && wd_clr)) |-> ovf_flag);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(ctl_wr && wd_flag)) |=> ovf_flag);
  // R5
  p_clr_reads0_r5: assert property (@(posedge clk) disable iff (rst)
    $past(addr_ctrl) |-> !rd_clr_bit);
endmodule

bind tmr_prescaled_counter tmr_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst),
  .ctl_wr(bus_wr && (bus_addr == '0)),
  .wd_stop(bus_wdata[5]), .wd_clr(bus_wdata[4]), .wd_flag(bus_wdata[7]),
  .addr_ctrl(bus_addr == '0), .rd_clr_bit(bus_rdata[4]),
  .capture_en(capture_en), .ovf_flag(ovf_flag), .cnt(cnt_q)
);

// File: tb/tmr_prescaled_counter_tb_top.sv
module tmr_prescaled_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        ext_clk_in = 1'b0;
  logic        ovf_flag, capture_en;
  logic        rd_req = 1'b0;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  typedef struct {string tag; logic [15:0] exp;} sb_item_t;
  sb_item_t sb_q[$];
  sb_item_t cur;

  always #5 clk = ~clk;

  tmr_prescaled_counter dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in), .ovf_flag(ovf_flag), .capture_en(capture_en)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 16'd0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [15:0] e, input string tag);
    bus_addr = a; rd_req = 1'b1;
    sb_q.push_back('{tag, e});
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop expected read data and compare once the design has loaded it
  always @(posedge clk) begin
    if (rd_req) begin
      #1;
      if (sb_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R10 scoreboard empty actual=0x%04h expected=none", bus_rdata);
      end else begin
        cur = sb_q.pop_front();
        check(cur.tag, bus_rdata, cur.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle(5);
    rst = 1'b0;
    // R1 reset state
    check("R1 capture_en", {15'd0, capture_en}, 16'd0);
    check("R1 ovf_flag", {15'd0, ovf_flag}, 16'd0);
    bus_read(2'd0, 16'h0020, "R1 ctrl word");
    idle(100);
    bus_read(2'd1, 16'h0000, "R1 count held");

    // R7 / R4 every divide ratio, one tick before and at the fifth tick
    for (int k = 0; k < 7; k++) begin
      bus_write(2'd0, 16'h0010 | 16'(k));
      idle((5 << k) - 1);
      bus_read(2'd1, 16'd4, $sformatf("R7 R4 ratio code %0d before tick", k));
      bus_read(2'd1, 16'd5, $sformatf("R7 R4 ratio code %0d at tick", k));
    end

    // R2 stop only: clear at ratio 64, stop after 131 cycles -> count 2 held
    bus_write(2'd0, 16'h0016);
    idle(130);
    bus_write(2'd0, 16'h0026);
    check("R3 capture_en after stop", {15'd0, capture_en}, 16'd0);
    bus_read(2'd1, 16'd2, "R2 count frozen");
    idle(300);
    bus_read(2'd1, 16'd2, "R2 count still frozen");
    bus_write(2'd0, 16'h0006);
    check("R3 capture_en after resume", {15'd0, capture_en}, 16'd1);
    idle(140);
    bus_read(2'd0, 16'h0006, "R10 ctrl readback");

    // R6 stop and clear in one write
    bus_write(2'd0, 16'h0030);
    bus_read(2'd1, 16'd0, "R6 cleared");
    idle(80);
    bus_read(2'd1, 16'd0, "R6 held at zero");
    check("R6 capture_en low", {15'd0, capture_en}, 16'd0);

    // R8 external edges
    bus_write(2'd0, 16'h0017);
    for (int p = 0; p < 5; p++) begin
      ext_clk_in = 1'b1; idle(4);
      ext_clk_in = 1'b0; idle(4);
    end
    idle(4);
    bus_read(2'd1, 16'd5, "R8 five edges");
    ext_clk_in = 1'b1; idle(50);
    bus_read(2'd1, 16'd6, "R8 level held counts once");
    ext_clk_in = 1'b0; idle(4);

    // R9 overflow at ratio 1
    bus_write(2'd0, 16'h0010);
    idle(65535);
    check("R9 flag before wrap", {15'd0, ovf_flag}, 16'd0);
    idle(1);
    check("R9 flag after wrap", {15'd0, ovf_flag}, 16'd1);
    bus_read(2'd1, 16'd0, "R9 count wrapped");
    idle(10);
    check("R9 flag sticky", {15'd0, ovf_flag}, 16'd1);
    // R5 clear without flag bit keeps flag, clear bit reads 0
    bus_write(2'd0, 16'h0010);
    check("R5 flag kept by clear", {15'd0, ovf_flag}, 16'd1);
    bus_read(2'd0, 16'h0080, "R5 ctrl word clear bit reads 0");
    bus_write(2'd0, 16'h00A0);
    check("R9 flag write-one-clear", {15'd0, ovf_flag}, 16'd0);
    bus_read(2'd0, 16'h0020, "R9 ctrl after flag clear");

    idle(3);
    finish_run();
  end
endmodule